// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave is holding because a transfer was cut off partway through a byte. The slave keeps SDA low because it is waiting for more clock edges. When asked, the sequencer checks two conditions: whether the master controller still reports busy, and whether SDA is sampled low. If either holds, it takes the SCL and SDA pads away from the controller and drives SCL itself. It toggles SCL at a slow, fixed pace until the slave lets go of SDA or a pulse budget runs out. It then parks SCL high for one more interval and hands the pads back.

Each phase of the sequence lasts one interval of `INTERVAL_CYC` clock cycles. The default is about one millisecond at 125 MHz. SDA passes through a synchronizer and is sampled `SAMPLE_LEAD` cycles before each low phase ends. The block raises a one-cycle completion pulse when the pads return. It flags failure if SDA was still low after the last allowed pulse. Sending a STOP condition afterwards is left to the controller.

Top module: `bus_clr_seq`

## Requirements
- R1: After reset `scl_o` is 1, and `pin_own_o`, `done_o` and `fail_o` are 0.
- R2: While idle, a `start_i` high at a clock edge is a request. If `ctrl_busy_i` is 1 or the synchronized SDA is 0, `pin_own_o` is 1 from the next cycle. Otherwise `pin_own_o` stays 0, `done_o` is 1 in the next cycle and `fail_o` becomes 0.
- R3: Once ownership is taken, `scl_o` is first held at 0 for exactly `INTERVAL_CYC` cycles.
- R4: SDA is sampled after `SYNC_STAGES` flops, `SAMPLE_LEAD` cycles before the end of each low phase. If the sample is 0 and pulses remain, one pulse follows: `scl_o` is 1 for `INTERVAL_CYC` cycles, then 0 for `INTERVAL_CYC` cycles.
- R5: At most `MAX_PULSES` pulses are issued. With p pulses, `pin_own_o` stays 1 for exactly (2p+2)·`INTERVAL_CYC` cycles.
- R6: After the loop ends, `scl_o` is 1 for exactly `INTERVAL_CYC` cycles before `pin_own_o` falls.
- R7: `done_o` is 1 for exactly one cycle, namely the first cycle with `pin_own_o` at 0 after a recovery.
- R8: `fail_o` is set together with `done_o` if and only if the last SDA sample was 0 and all `MAX_PULSES` pulses were used. It holds its value until the next accepted request clears it.
- R9: `start_i` has no effect while `pin_own_o` is 1.
- R10: While `pin_own_o` is 0, `scl_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Recovery request |
| sda_i | input | 1 | Raw SDA pad level |
| ctrl_busy_i | input | 1 | Master controller busy flag |
| scl_o | output | 1 | SCL level driven while the sequencer owns the pads |
| pin_own_o | output | 1 | 1: pads under sequencer control, 0: controller owns pads |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA still low after the pulse budget |

## Verification
A wrong state or interval count shows up as an ownership window that is not a multiple of the interval matching the pulse count. It is visible at the pad release, within one recovery. A miscounted pulse budget or a bad SDA sample shows up as a wrong number of SCL rising edges and a wrong `fail_o`, both reported together with `done_o`. The bench models a slave that lets go of SDA after a chosen number of SCL rises. From that number it predicts every phase length, and the check happens as soon as the pads return.

// File: rtl/bus_clr_pkg.sv
package bus_clr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_PARK
  } clr_state_e;
endpackage

// File: rtl/bus_clr_sync.sv
module bus_clr_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= RST_VAL;
        else         ff_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= RST_VAL;
        else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/bus_clr_timer.sv
module bus_clr_timer #(
  parameter int unsigned INTERVAL_CYC = 125000,
  parameter int unsigned SAMPLE_LEAD  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sample_o,
  output logic expire_o
);
  localparam int unsigned CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);
  localparam logic [CW-1:0] SMP  = CW'(INTERVAL_CYC - 1 - SAMPLE_LEAD);

  logic [CW-1:0] cnt_q;

  // every phase is one interval long, so the counter simply wraps
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;

  assign sample_o = run_i && (cnt_q == SMP);
  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bus_clr_attempts.sv
module bus_clr_attempts #(
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int unsigned AW = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] TOP = AW'(MAX_PULSES);

  logic [AW-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      used_q <= '0;
    else if (clr_i)   used_q <= '0;
    else if (inc_i && used_q != TOP) used_q <= used_q + 1'b1;

  assign spent_o = (used_q == TOP);
endmodule

// File: rtl/bus_clr_seq.sv
module bus_clr_seq
  import bus_clr_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 125000,
  parameter int unsigned MAX_PULSES   = 9,
  parameter int unsigned SAMPLE_LEAD  = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_i,
  input  logic ctrl_busy_i,
  output logic scl_o,
  output logic pin_own_o,
  output logic done_o,
  output logic fail_o
);
  clr_state_e state_q, state_d;
  logic sda_s, sample, expire, spent;
  logic sda_smp_q, fail_pend_q, fail_pend_d;
  logic done_q, fail_q;
  logic accept, clr_att, inc_att;

  bus_clr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s)
  );

  bus_clr_timer #(.INTERVAL_CYC(INTERVAL_CYC), .SAMPLE_LEAD(SAMPLE_LEAD)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state_q != ST_IDLE),
    .sample_o(sample), .expire_o(expire)
  );

  bus_clr_attempts #(.MAX_PULSES(MAX_PULSES)) u_att (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_att), .inc_i(inc_att), .spent_o(spent)
  );

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d     = state_q;
    fail_pend_d = fail_pend_q;
    clr_att     = 1'b0;
    inc_att     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept && (ctrl_busy_i || !sda_s)) begin
        state_d     = ST_LOW;
        fail_pend_d = 1'b0;
        clr_att     = 1'b1;
      end
      ST_LOW: if (expire) begin
        if (sda_smp_q || spent) begin
          state_d     = ST_PARK;
          fail_pend_d = !sda_smp_q;
        end else begin
          state_d = ST_HIGH;
          inc_att = 1'b1;
        end
      end
      ST_HIGH: if (expire) state_d = ST_LOW;
      ST_PARK: if (expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fail_pend_q <= 1'b0;
      sda_smp_q   <= 1'b1;
    end else begin
      state_q     <= state_d;
      fail_pend_q <= fail_pend_d;
      if (state_q == ST_LOW && sample) sda_smp_q <= sda_s;
    end

  // done and fail move together, on release or on a no-op request
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_PARK && expire) begin
        done_q <= 1'b1;
        fail_q <= fail_pend_q;
      end else if (accept) begin
        fail_q <= 1'b0;
        if (!(ctrl_busy_i || !sda_s)) done_q <= 1'b1;
      end
    end

  assign scl_o     = (state_q != ST_LOW);
  assign pin_own_o = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/bus_clr_seq_chk.sv
module bus_clr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scl_o,
  input logic pin_own_o,
  input logic done_o,
  input logic fail_o
);
  a_r10_scl_high_unowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_own_o |-> scl_o);
  a_r7_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_own_o) |-> done_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_unowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pin_own_o);
  a_r2_own_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_own_o) |-> $past(start_i));
  a_r8_fail_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fail_o) |-> (done_o || $past(start_i)));
  a_r9_no_done_while_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_own_o && start_i) |=> (pin_own_o || done_o));
endmodule

bind bus_clr_seq bus_clr_seq_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .scl_o(scl_o),
  .pin_own_o(pin_own_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/bus_clr_seq_tb.sv
module bus_clr_seq_tb_top;
  localparam int IV   = 16;
  localparam int MAXP = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, sda_i = 1'b1, ctrl_busy_i = 1'b0;
  logic scl_o, pin_own_o, done_o, fail_o;
  int checks = 0, errors = 0, cyc_total = 0;

  always #4 clk = ~clk;

  bus_clr_seq #(.INTERVAL_CYC(IV), .MAX_PULSES(MAXP), .SAMPLE_LEAD(2), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sda_i(sda_i),
    .ctrl_busy_i(ctrl_busy_i), .scl_o(scl_o), .pin_own_o(pin_own_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input bit low, input int n);
    if (!low) return 0;
    return (n > MAXP) ? MAXP : n;
  endfunction

  function automatic bit exp_fail(input bit low, input int n);
    return low && (n > MAXP);
  endfunction

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc_total);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input bit busy, input bit low, input int n_rel, input bit mid_start);
    bit need = busy || low;
    int p = exp_pulses(low, n_rel);
    int own_cyc = 0, low_cyc = 0, rises = 0, last_rise = 0, first_rise = -1;
    int cyc = 0, done_at = -1;
    bit prev_scl = 1'b1, got_fail = 1'b0;
    @(negedge clk);
    ctrl_busy_i = busy;
    sda_i = !low;
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 own after request", pin_own_o, need);
    if (need) chk("R3 scl low at entry", scl_o, 0);
    while (cyc < 2000) begin
      if (mid_start) start_i = (cyc == 20);
      if (pin_own_o) begin
        own_cyc++;
        if (!scl_o) low_cyc++;
        if (scl_o && !prev_scl) begin
          rises++;
          last_rise = cyc;
          if (first_rise < 0) first_rise = cyc;
          if (low && rises == n_rel) sda_i = 1'b1;
        end
      end else chk("R10 scl high unowned", scl_o, 1);
      prev_scl = scl_o;
      if (done_o) begin
        done_at = cyc;
        got_fail = fail_o;
        break;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk("R5 own cycles", own_cyc, need ? (2*p+2)*IV : 0);
    chk("R7 done at release", done_at, own_cyc);
    chk("R8 fail flag", got_fail, exp_fail(low, n_rel));
    if (need) begin
      chk("R4 scl rises", rises, p+1);
      chk("R4 low cycles", low_cyc, (p+1)*IV);
      chk("R3 first low length", first_rise, IV);
      chk("R6 final high hold", own_cyc - last_rise, IV);
    end
    @(negedge clk);
    chk("R7 done single cycle", done_o, 0);
    repeat (3) @(negedge clk);
    chk("R8 fail held", fail_o, exp_fail(low, n_rel));
    sda_i = 1'b1;
    ctrl_busy_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 scl reset", scl_o, 1);
    chk("R1 own reset", pin_own_o, 0);
    chk("R1 done reset", done_o, 0);
    chk("R1 fail reset", fail_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    run_case(1'b0, 1'b0, 0, 1'b0);      // R2 clean bus, no recovery
    run_case(1'b1, 1'b0, 0, 1'b0);      // R2 busy only, zero pulses
    run_case(1'b0, 1'b1, 1, 1'b0);      // R4 one pulse
    run_case(1'b0, 1'b1, MAXP, 1'b0);   // R5 exactly at budget
    run_case(1'b0, 1'b1, MAXP+1, 1'b0); // R8 budget exceeded
    run_case(1'b0, 1'b0, 0, 1'b0);      // R8 fail cleared by next request
    run_case(1'b1, 1'b1, 3, 1'b1);      // R9 request while owned ignored
    run_case(1'b0, 1'b1, 50, 1'b0);     // R8 slave never lets go
    for (int i = 0; i < 16; i++) begin
      bit b = 1'($urandom() & 1);
      bit l = 1'($urandom() & 1);
      int n = 1 + int'($urandom() % 12);
      bit m = 1'($urandom() & 1);
      run_case(b, l, n, m);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule